// File: doc/BRIEF.md
# Two-Wire Tuning Register Slave with Temperature Snapshot

This block is a two-wire serial (I2C) slave in front of a four-byte register space inside a temperature-compensated oscillator controller. A system clock oversamples the SCL and SDA lines and finds START, STOP and repeated START on them. Only one fixed 7-bit address gets a reply. In a write, the first byte after the address sets a register pointer, and each later byte is stored at that pointer. A read sends bytes starting at the stored pointer, and that pointer is kept from one transaction to the next.

Two bytes hold a frequency trim word, and both bytes go straight to the compensation engine. A pulse marks each completed write of the low trim byte. The other two bytes show a 12-bit temperature code. This code is a snapshot of the live sensor value, taken only when a write-direction address matches and when a word address arrives. So a master that sets the pointer and then reads both temperature bytes gets one consistent value, even while the sensor keeps updating.

Top module: `tune_reg_i2c_slave`

## Requirements
- R1: The slave acknowledges (pulls SDA low during the ninth clock) only address bytes 82h (write) and 83h (read). Any other address gets no acknowledge, and the slave then leaves SDA released for every later byte until the next START or STOP.
- R2: In a write, the byte after the address loads the pointer from its two low bits. Each following data byte is acknowledged, stored at the pointer, and moves the pointer on by one, with 03h wrapping to 00h.
- R3: Read data by pointer value: 00h gives the high trim byte, 01h the low trim byte, 02h temperature bits 11..4, and 03h temperature bits 3..0 in bits 7..4 with bits 3..0 reading 0. Data is sent MSB first.
- R4: A read starts at the stored pointer even when no word address was written first. The pointer moves on by one for every byte sent and keeps its value across transactions.
- R5: When the master answers a read byte with NACK, the slave releases SDA and drives nothing more until the next START.
- R6: The readable temperature copy takes the live sensor value when a matching write address is received and when a word address is received. Reads never refresh it.
- R7: After reset both trim bytes are 00h and the temperature copy is 190h, so it reads back as 19h and 00h.
- R8: Data bytes written to 02h or 03h are acknowledged but change nothing.
- R9: tune_hi_o and tune_lo_o always show the two trim bytes. tune_lo_wr_o gives exactly one single-cycle pulse for each completed data write to 01h.
- R10: A repeated START without a STOP restarts address reception, so a read can follow a pointer write directly.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8 times the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level, as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| temp_live_i | input | 12 | Live temperature code from the sensor |
| tune_hi_o | output | 8 | High trim byte (bit 7 holds the compensation freeze flag) |
| tune_lo_o | output | 8 | Low trim byte |
| tune_lo_wr_o | output | 1 | One-cycle pulse after each write to the low trim byte |

## Verification
The hardest case to reach is showing that the temperature copy is not refreshed. The live input has to change between transactions, and the master must then read without writing a word address, because a word address would take a new snapshot on purpose. The bench does this by leaving the pointer on the temperature bytes after a wrapped multi-byte read, changing the live code, and reading again, so the old code must come back. The same sequence, with NACKs placed at chosen points, also shows that the pointer keeps its value between separate read transactions.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_WORD,
    PH_WDATA,
    PH_RDATA
  } phase_t;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PTR_W  = 2;
  localparam int unsigned CNT_W  = 4;
endpackage

// File: rtl/tsl_line_sync.sv
module tsl_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_prev, sda_prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s_o    = scl_pipe[STAGES-1];
  assign sda_s_o    = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_s_o & ~scl_prev;
  assign scl_fall_o = ~scl_s_o & scl_prev;
  assign start_o    = scl_s_o & scl_prev & sda_prev & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_prev & ~sda_prev & sda_s_o;
endmodule

// File: rtl/tsl_proto.sv
module tsl_proto
  import tsl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h41
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              ptr_set_o,
  output logic              ptr_step_o,
  output logic              wr_en_o,
  output logic              snap_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              sda_oe_o
);
  phase_t             phase_q, phase_d;
  logic [CNT_W-1:0]   bit_q, bit_d;
  logic [BYTE_W-1:0]  rx_q, rx_d;
  logic [BYTE_W-1:0]  tx_q, tx_d;
  logic               in_ack_q, in_ack_d;
  logic               ack_drv_q, ack_drv_d;
  logic               mack_q, mack_d;

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  always_comb begin
    phase_d    = phase_q;
    bit_d      = bit_q;
    rx_d       = rx_q;
    tx_d       = tx_q;
    in_ack_d   = in_ack_q;
    ack_drv_d  = ack_drv_q;
    mack_d     = mack_q;
    ptr_set_o  = 1'b0;
    ptr_step_o = 1'b0;
    wr_en_o    = 1'b0;
    snap_o     = 1'b0;
    if (start_i) begin
      phase_d   = PH_ADDR;
      bit_d     = '0;
      in_ack_d  = 1'b0;
      ack_drv_d = 1'b0;
    end else if (stop_i) begin
      phase_d   = PH_IDLE;
      bit_d     = '0;
      in_ack_d  = 1'b0;
      ack_drv_d = 1'b0;
    end else if (phase_q != PH_IDLE) begin
      if (scl_rise_i) begin
        if (in_ack_q) begin
          mack_d = ~sda_s_i;
        end else begin
          rx_d  = {rx_q[BYTE_W-2:0], sda_s_i};
          bit_d = bit_q + 1'b1;
        end
      end else if (scl_fall_i) begin
        if (in_ack_q) begin
          in_ack_d  = 1'b0;
          ack_drv_d = 1'b0;
          bit_d     = '0;
          if (phase_q == PH_RDATA) begin
            if (ack_drv_q || mack_q) begin
              tx_d       = rdata_i;
              ptr_step_o = 1'b1;
            end else begin
              phase_d = PH_IDLE;
            end
          end
        end else if (bit_q == LAST_BIT) begin
          in_ack_d = 1'b1;
          unique case (phase_q)
            PH_ADDR: begin
              if (rx_q[BYTE_W-1:1] == DEV_ADDR) begin
                ack_drv_d = 1'b1;
                if (rx_q[0]) begin
                  phase_d = PH_RDATA;
                end else begin
                  phase_d = PH_WORD;
                  snap_o  = 1'b1;
                end
              end else begin
                phase_d = PH_IDLE;
              end
            end
            PH_WORD: begin
              ack_drv_d = 1'b1;
              ptr_set_o = 1'b1;
              snap_o    = 1'b1;
              phase_d   = PH_WDATA;
            end
            PH_WDATA: begin
              ack_drv_d = 1'b1;
              wr_en_o   = 1'b1;
            end
            default: ;
          endcase
        end else if (phase_q == PH_RDATA && bit_q != '0) begin
          tx_d = {tx_q[BYTE_W-2:0], 1'b1};
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      bit_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '1;
      in_ack_q  <= 1'b0;
      ack_drv_q <= 1'b0;
      mack_q    <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      bit_q     <= bit_d;
      rx_q      <= rx_d;
      tx_q      <= tx_d;
      in_ack_q  <= in_ack_d;
      ack_drv_q <= ack_drv_d;
      mack_q    <= mack_d;
    end
  end

  assign byte_o   = rx_q;
  assign sda_oe_o = ack_drv_q | ((phase_q == PH_RDATA) & ~in_ack_q & ~tx_q[BYTE_W-1]);
endmodule

// File: rtl/tsl_regs.sv
module tsl_regs
  import tsl_pkg::*;
#(
  parameter int unsigned    TEMP_W   = 12,
  parameter logic [TEMP_W-1:0] TEMP_RST = 12'h190
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ptr_set_i,
  input  logic              ptr_step_i,
  input  logic              wr_en_i,
  input  logic              snap_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [TEMP_W-1:0] temp_live_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [BYTE_W-1:0] tune_hi_o,
  output logic [BYTE_W-1:0] tune_lo_o,
  output logic              lo_wr_o,
  output logic [TEMP_W-1:0] temp_o
);
  localparam int unsigned LO_BITS = TEMP_W - BYTE_W;
  localparam logic [PTR_W-1:0] IDX_HI = 2'd0;
  localparam logic [PTR_W-1:0] IDX_LO = 2'd1;
  localparam logic [PTR_W-1:0] IDX_TH = 2'd2;

  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [BYTE_W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic [TEMP_W-1:0] temp_q, temp_d;
  logic              pulse_q, pulse_d;

  always_comb begin
    ptr_d   = ptr_q;
    hi_d    = hi_q;
    lo_d    = lo_q;
    temp_d  = temp_q;
    pulse_d = 1'b0;
    if (snap_i) temp_d = temp_live_i;
    if (ptr_set_i) begin
      ptr_d = byte_i[PTR_W-1:0];
    end else if (wr_en_i) begin
      if (ptr_q == IDX_HI) hi_d = byte_i;
      if (ptr_q == IDX_LO) begin
        lo_d    = byte_i;
        pulse_d = 1'b1;
      end
      ptr_d = ptr_q + 1'b1;
    end else if (ptr_step_i) begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      temp_q  <= TEMP_RST;
      pulse_q <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
      temp_q  <= temp_d;
      pulse_q <= pulse_d;
    end
  end

  always_comb begin
    unique case (ptr_q)
      IDX_HI:  rdata_o = hi_q;
      IDX_LO:  rdata_o = lo_q;
      IDX_TH:  rdata_o = temp_q[TEMP_W-1:LO_BITS];
      default: rdata_o = {temp_q[LO_BITS-1:0], {(BYTE_W-LO_BITS){1'b0}}};
    endcase
  end

  assign tune_hi_o = hi_q;
  assign tune_lo_o = lo_q;
  assign lo_wr_o   = pulse_q;
  assign temp_o    = temp_q;
endmodule

// File: rtl/tune_reg_i2c_slave.sv
module tune_reg_i2c_slave
  import tsl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h41,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TEMP_W      = 12,
  parameter logic [TEMP_W-1:0] TEMP_RST = 12'h190
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [TEMP_W-1:0] temp_live_i,
  output logic [7:0]        tune_hi_o,
  output logic [7:0]        tune_lo_o,
  output logic              tune_lo_wr_o
);
  logic [1:0]        rst_pipe;
  logic              rst_n;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic              ptr_set, ptr_step, wr_en, snap;
  logic [BYTE_W-1:0] rx_byte, rdata;
  logic [TEMP_W-1:0] temp_user;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= '0;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n = rst_pipe[1];

  tsl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_s_o    (scl_s),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  tsl_proto #(.DEV_ADDR(DEV_ADDR)) u_proto (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_ev),
    .stop_i     (stop_ev),
    .rdata_i    (rdata),
    .ptr_set_o  (ptr_set),
    .ptr_step_o (ptr_step),
    .wr_en_o    (wr_en),
    .snap_o     (snap),
    .byte_o     (rx_byte),
    .sda_oe_o   (sda_oe_o)
  );

  tsl_regs #(.TEMP_W(TEMP_W), .TEMP_RST(TEMP_RST)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .ptr_set_i   (ptr_set),
    .ptr_step_i  (ptr_step),
    .wr_en_i     (wr_en),
    .snap_i      (snap),
    .byte_i      (rx_byte),
    .temp_live_i (temp_live_i),
    .rdata_o     (rdata),
    .tune_hi_o   (tune_hi_o),
    .tune_lo_o   (tune_lo_o),
    .lo_wr_o     (tune_lo_wr_o),
    .temp_o      (temp_user)
  );
endmodule

// File: rtl/tsl_checker.sv
module tsl_checker #(
  parameter int unsigned TEMP_W = 12
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              scl_s,
  input logic              stop_ev,
  input logic              sda_oe,
  input logic              lo_pulse,
  input logic              wr_en,
  input logic              snap,
  input logic [7:0]        tune_hi,
  input logic [7:0]        tune_lo,
  input logic [TEMP_W-1:0] temp_user
);
  AST_STOP_RELEASES_SDA: assert property (@(posedge clk_i) disable iff (!rst_n)
    stop_ev |=> !sda_oe); // R5
  AST_TUNE_HELD_WITHOUT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_n)
    !wr_en |=> ($stable(tune_hi) && $stable(tune_lo))); // R2
  AST_LO_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    lo_pulse |=> !lo_pulse); // R9
  AST_TEMP_HELD_WITHOUT_SNAP: assert property (@(posedge clk_i) disable iff (!rst_n)
    !snap |=> $stable(temp_user)); // R6
  AST_DRIVE_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s); // R11
endmodule

bind tune_reg_i2c_slave tsl_checker #(.TEMP_W(TEMP_W)) u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .stop_ev   (stop_ev),
  .sda_oe    (sda_oe_o),
  .lo_pulse  (tune_lo_wr_o),
  .wr_en     (wr_en),
  .snap      (snap),
  .tune_hi   (tune_hi_o),
  .tune_lo   (tune_lo_o),
  .temp_user (temp_user)
);

// File: tb/tune_reg_i2c_slave_test.sv
`timescale 1ns/1ps
module tune_reg_i2c_slave_test;
  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [11:0] temp_live = 12'hABC;
  logic        sda_oe;
  logic [7:0]  tune_hi, tune_lo;
  logic        lo_wr;
  wire         sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  int viol = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic oe_prev = 1'b0;

  always #2 clk = ~clk;

  tune_reg_i2c_slave uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .scl_i        (scl_m),
    .sda_i        (sda_bus),
    .sda_oe_o     (sda_oe),
    .temp_live_i  (temp_live),
    .tune_hi_o    (tune_hi),
    .tune_lo_o    (tune_lo),
    .tune_lo_wr_o (lo_wr)
  );

  always @(posedge clk) begin
    if (lo_wr) pulses++;
    if (rst_n && sda_oe !== oe_prev && scl_m) viol++;
    oe_prev <= sda_oe;
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic clock_bit(input logic b, output logic s);
    sda_m = b;    tick(Q);
    scl_m = 1'b1; tick(Q);
    s = sda_bus;  tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      b[i] = s;
    end
    clock_bit(~mack, s);
  endtask

  task automatic t_reset();
    logic ack;
    logic [7:0] d;
    chk("R7 tune_hi after reset", tune_hi, 8'h00);
    chk("R7 tune_lo after reset", tune_lo, 8'h00);
    bus_start();
    send_byte(8'h83, ack); chk("R1 read address acked", ack, 1);
    recv_byte(1, d); chk("R3 R4 byte 00h at reset", d, 8'h00);
    recv_byte(1, d); chk("R3 byte 01h at reset", d, 8'h00);
    recv_byte(1, d); chk("R7 R6 temp high at reset", d, 8'h19);
    recv_byte(0, d); chk("R7 temp low at reset", d, 8'h00);
    bus_stop();
  endtask

  task automatic t_write();
    logic ack;
    bus_start();
    send_byte(8'h82, ack); chk("R1 write address acked", ack, 1);
    send_byte(8'h00, ack); chk("R2 word address acked", ack, 1);
    send_byte(8'hA5, ack); chk("R2 data 00h acked", ack, 1);
    send_byte(8'h3C, ack); chk("R2 data 01h acked", ack, 1);
    bus_stop();
    chk("R9 tune_hi export", tune_hi, 8'hA5);
    chk("R9 tune_lo export", tune_lo, 8'h3C);
    chk("R9 one pulse per low write", pulses, 1);
  endtask

  task automatic t_readback_release();
    logic ack, s;
    logic [7:0] d;
    int lows = 0;
    bus_start();
    send_byte(8'h83, ack); chk("R4 read acked", ack, 1);
    recv_byte(1, d); chk("R3 R6 temp high snapshot", d, 8'hAB);
    recv_byte(0, d); chk("R3 temp low nibble", d, 8'hC0);
    for (int i = 0; i < 9; i++) begin
      clock_bit(1'b1, s);
      if (!s) lows++;
    end
    chk("R5 SDA released after NACK", lows, 0);
    bus_stop();
  endtask

  task automatic t_persist();
    logic ack;
    logic [7:0] d;
    temp_live = 12'h123;
    bus_start(); send_byte(8'h83, ack);
    recv_byte(0, d); chk("R4 wrapped pointer read", d, 8'hA5);
    bus_stop();
    bus_start(); send_byte(8'h83, ack);
    recv_byte(0, d); chk("R4 pointer kept across reads", d, 8'h3C);
    bus_stop();
    bus_start(); send_byte(8'h83, ack);
    recv_byte(1, d); chk("R6 read gives no refresh (high)", d, 8'hAB);
    recv_byte(0, d); chk("R6 read gives no refresh (low)", d, 8'hC0);
    bus_stop();
  endtask

  task automatic t_wrap_ignore();
    logic ack;
    logic [7:0] d;
    temp_live = 12'h456;
    bus_start();
    send_byte(8'h82, ack);
    send_byte(8'h03, ack);
    send_byte(8'h11, ack); chk("R8 write to 03h acked", ack, 1);
    send_byte(8'h22, ack); chk("R2 wrap write acked", ack, 1);
    bus_stop();
    chk("R2 wrap lands on 00h", tune_hi, 8'h22);
    chk("R8 low trim untouched", tune_lo, 8'h3C);
    bus_start();
    send_byte(8'h82, ack);
    send_byte(8'h02, ack);
    send_byte(8'hFF, ack); chk("R8 write to 02h acked", ack, 1);
    send_byte(8'hFF, ack);
    bus_stop();
    bus_start(); send_byte(8'h83, ack);
    recv_byte(1, d); chk("R2 pointer wrapped to 00h", d, 8'h22);
    recv_byte(1, d); chk("R3 low trim", d, 8'h3C);
    recv_byte(1, d); chk("R8 R6 temp high not overwritten", d, 8'h45);
    recv_byte(0, d); chk("R8 temp low not overwritten", d, 8'h60);
    bus_stop();
    chk("R9 no pulse without low write", pulses, 1);
  endtask

  task automatic t_bad_addr();
    logic ack;
    bus_start();
    send_byte(8'h84, ack); chk("R1 foreign address not acked", ack, 0);
    send_byte(8'h00, ack); chk("R1 stays off bus after mismatch", ack, 0);
    bus_stop();
    chk("R1 mismatch writes nothing", tune_hi, 8'h22);
  endtask

  task automatic t_restart();
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte(8'h82, ack);
    send_byte(8'h01, ack);
    bus_start();
    send_byte(8'h83, ack); chk("R10 address after repeated START acked", ack, 1);
    recv_byte(0, d); chk("R10 read from pointer set before restart", d, 8'h3C);
    bus_stop();
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_write();
    t_readback_release();
    t_persist();
    t_wrap_ignore();
    t_bad_addr();
    t_restart();
    chk("R11 drive changes with SCL low", viol, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule